// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers 32 main interrupt sources and 11 secondary sources and drives one normal interrupt line (`irq_o`) and one fast interrupt line (`fiq_o`) toward a processor. Every source input is edge detected and latched into a pending register, whether or not it is masked. Secondary sources have their own pending and mask registers. Each unmasked secondary pending bit keeps a designated parent main source pending. Main pending bits that pass the mask are routed by a mode register either straight to the fast line or into a two-stage priority tree.

The tree has six group arbiters with rotatable orders, followed by a group-level arbiter. The overall winner is recorded as a single bit in an in-service register and as a 5-bit index in an offset register. The interrupt service routine reads the offset to find the source. It then clears the source's pending bit, and after that its in-service bit, by writing ones. All registers are reached through a small synchronous register port with a combinational read path.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset, the main mask reads 0xFFFFFFFF and the secondary mask reads 0x7FF. Main pending, secondary pending, mode, priority configuration, in-service and offset all read 0, and both `irq_o` and `fiq_o` are low.
- R2: A main pending bit is set on the clock edge after its `src_in` bit rises, whatever its mask bit is. An input held high sets the bit only once, so after the bit is cleared it stays clear while the input remains high.
- R3: The main pending, secondary pending and in-service registers are write-one-to-clear. A written 1 clears the matching bit and a written 0 leaves the bit unchanged.
- R4: A mask bit of 1 keeps its pending source off both output lines and out of arbitration. Once the mask bit is cleared, the pending source is serviced.
- R5: A mode bit of 1 sends its unmasked pending source to `fiq_o`, which stays high while that source is pending. Such a source never enters the in-service register and never changes the offset register. A mode bit of 0 sends the source to arbitration.
- R6: The in-service register loads only when it is empty and an unmasked normal-mode candidate exists, and it then holds exactly one bit. `offset` holds that bit's index, and `irq_o` is high while any in-service bit is set. A newly arriving candidate never replaces the source already in service, whatever its priority.
- R7: Group 0 takes main bits 0 to 3 on arbiter inputs 1 to 4, with inputs 0 and 5 tied low. Each group g of 1 to 5 takes bits 4+6(g-1) and up on inputs 0 to 5, and the inputs of group 5 beyond bit 31 are tied low. Group g's winner is input g of the group-level arbiter, so with default settings bit 0 beats bit 31 and bit 4 beats bit 16.
- R8: Each arbiter has a 2-bit order select s. Input 0 always comes first and input 5 always comes last. Between them come inputs 1 to 4, starting at input 1+s and wrapping from 4 back to 1.
- R9: When an arbiter's rotate enable is 1 and the input it granted is serviced, its select becomes 1, 2, 3 or 0 for a granted input of 1, 2, 3 or 4 respectively. A grant of input 0 or 5 leaves the select unchanged. Only the arbiters on the winner's path update. With rotate disabled, the select changes only when it is written.
- R10: A secondary pending bit is set on the clock edge after its `sub_in` bit rises, whatever the secondary mask is. While a secondary pending bit is set and unmasked, it sets its parent main pending bit: secondary bits 0 to 2 go to main bit 28, bits 3 to 5 to bit 23, bits 6 to 8 to bit 15, and bits 9 and 10 to bit 31.
- R11: Register addresses are: 0 main pending, 1 mode, 2 main mask, 3 priority configuration, 4 in-service, 5 offset (read-only, writes ignored), 6 secondary pending, 7 secondary mask. In the priority configuration, arbiter k (0 to 5 for the groups, 6 for the group-level arbiter) has its order select in bits [2k+1:2k] and its rotate enable in bit 16+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Main interrupt source lines, rising-edge sensitive |
| sub_in | input | 11 | Secondary interrupt source lines, rising-edge sensitive |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request, high while a source is in service |
| fiq_o | output | 1 | Fast interrupt request from an unmasked fast-mode source |

## Verification
The bench targets the following corner cases.
- **Input held high.** An input that stays high must not re-latch once cleared; a level-sensitive design would raise the bit again at once.
- **Fixed arbiter ends.** Arbiter input 0 must win and input 5 must lose under every select value. A design that rotated all six inputs would service the lowest source too early.
- **Group 0 layout.** Its sources sit on inputs 1 to 4. Getting this wrong shows up as a wrong offset when bits 0 and 1 compete under a nonzero select.
- **Rotation and precedence.** The bench checks that rotation moves only the winning path's select, that a late high-priority source cannot displace the one in service, that fast-mode sources leave the in-service and offset registers untouched, and that a masked secondary source stays off its parent bit until it is unmasked.

// File: rtl/irq_tree_pkg.sv
`timescale 1ns/1ps
package irq_tree_pkg;

  localparam int ARB_IN   = 6;
  localparam int SEL_W    = 2;
  localparam int ROT_BASE = 16;

  typedef enum logic [2:0] {
    RA_PEND    = 3'd0,
    RA_MODE    = 3'd1,
    RA_MASK    = 3'd2,
    RA_PRIO    = 3'd3,
    RA_INSVC   = 3'd4,
    RA_OFFSET  = 3'd5,
    RA_SUBPEND = 3'd6,
    RA_SUBMASK = 3'd7
  } reg_addr_e;

  // Source bit feeding arbiter input l of group g, or -1 when tied low.
  function automatic int grp_src_index(int g, int l, int nsrc);
    int b;
    if (g == 0) b = (l >= 1 && l <= 4) ? l - 1 : -1;
    else        b = 4 + ARB_IN * (g - 1) + l;
    if (b >= nsrc) b = -1;
    return b;
  endfunction

  function automatic int grp_count(int nsrc);
    return 1 + (nsrc - 4 + ARB_IN - 1) / ARB_IN;
  endfunction

  // Returns {valid, index}: input 0 first, then 1+s.. wrapping over 1..4, input 5 last.
  function automatic logic [3:0] arb_pick(logic [ARB_IN-1:0] req, logic [SEL_W-1:0] sel);
    logic [1:0] r;
    logic [2:0] idx;
    if (req[0]) return {1'b1, 3'd0};
    for (int k = 0; k < 4; k++) begin
      r   = sel + 2'(k);
      idx = {1'b0, r} + 3'd1;
      if (req[idx]) return {1'b1, idx};
    end
    if (req[5]) return {1'b1, 3'd5};
    return 4'b0000;
  endfunction

  // Order select after servicing input idx in rotate mode.
  function automatic logic [SEL_W-1:0] sel_after(logic [SEL_W-1:0] sel, logic [2:0] idx);
    case (idx)
      3'd1:    return 2'd1;
      3'd2:    return 2'd2;
      3'd3:    return 2'd3;
      3'd4:    return 2'd0;
      default: return sel;
    endcase
  endfunction

endpackage

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
module irq_edge_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] lvl_set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] src_prev;
  logic [W-1:0] clr_mask;
  logic [W-1:0] set_mask;

  assign rise_o   = src_i & ~src_prev;
  assign set_mask = rise_o | lvl_set_i;
  assign clr_mask = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_prev <= '0;
      pend_o   <= '0;
    end else begin
      src_prev <= src_i;
      pend_o   <= (pend_o & ~clr_mask) | set_mask;
    end
  end

endmodule

// File: rtl/irq_arb6.sv
`timescale 1ns/1ps
module irq_arb6
  import irq_tree_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARB_IN-1:0] req_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic              cfg_rot_i,
  input  logic              take_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              rot_o,
  output logic              win_valid_o,
  output logic [2:0]        win_idx_o
);

  logic [3:0] pick;

  assign pick        = arb_pick(req_i, sel_o);
  assign win_valid_o = pick[3];
  assign win_idx_o   = pick[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_o <= '0;
      rot_o <= 1'b0;
    end else if (cfg_we_i) begin
      sel_o <= cfg_sel_i;
      rot_o <= cfg_rot_i;
    end else if (take_i && rot_o && win_valid_o) begin
      sel_o <= sel_after(sel_o, win_idx_o);
    end
  end

endmodule

// File: rtl/irq_prio_tree.sv
`timescale 1ns/1ps
module irq_prio_tree
  import irq_tree_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IW   = $clog2(NSRC),
  localparam int NARB = ARB_IN + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       cand_i,
  input  logic                  load_i,
  input  logic                  cfg_we_i,
  input  logic [NARB*SEL_W-1:0] cfg_sel_i,
  input  logic [NARB-1:0]       cfg_rot_i,
  output logic [NARB*SEL_W-1:0] sel_o,
  output logic [NARB-1:0]       rot_o,
  output logic                  any_o,
  output logic [IW-1:0]         win_bit_o,
  output logic [NSRC-1:0]       win_onehot_o
);

  localparam int NGRP = grp_count(NSRC);
  localparam int TOP  = ARB_IN;

  logic [NGRP-1:0][ARB_IN-1:0] greq;
  logic [NGRP-1:0]             gvalid;
  logic [NGRP-1:0][2:0]        gidx;
  logic [ARB_IN-1:0]           treq;
  logic [2:0]                  top_idx;

  for (genvar g = 0; g < ARB_IN; g++) begin : g_grp
    if (g < NGRP) begin : g_used
      for (genvar l = 0; l < ARB_IN; l++) begin : g_in
        localparam int SI = grp_src_index(g, l, NSRC);
        if (SI >= 0) begin : g_wire
          assign greq[g][l] = cand_i[SI];
        end else begin : g_tie
          assign greq[g][l] = 1'b0;
        end
      end
      irq_arb6 u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (greq[g]),
        .cfg_we_i   (cfg_we_i),
        .cfg_sel_i  (cfg_sel_i[g*SEL_W +: SEL_W]),
        .cfg_rot_i  (cfg_rot_i[g]),
        .take_i     (load_i && (top_idx == 3'(g))),
        .sel_o      (sel_o[g*SEL_W +: SEL_W]),
        .rot_o      (rot_o[g]),
        .win_valid_o(gvalid[g]),
        .win_idx_o  (gidx[g])
      );
      assign treq[g] = gvalid[g];
    end else begin : g_absent
      assign sel_o[g*SEL_W +: SEL_W] = '0;
      assign rot_o[g]                = 1'b0;
      assign treq[g]                 = 1'b0;
    end
  end

  irq_arb6 u_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (treq),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i[TOP*SEL_W +: SEL_W]),
    .cfg_rot_i  (cfg_rot_i[TOP]),
    .take_i     (load_i),
    .sel_o      (sel_o[TOP*SEL_W +: SEL_W]),
    .rot_o      (rot_o[TOP]),
    .win_valid_o(any_o),
    .win_idx_o  (top_idx)
  );

  always_comb begin
    int b;
    b = -1;
    for (int g = 0; g < NGRP; g++) begin
      if (top_idx == 3'(g)) b = grp_src_index(g, int'(gidx[g]), NSRC);
    end
    win_bit_o    = (b >= 0) ? IW'(b) : '0;
    win_onehot_o = any_o ? (NSRC'(1) << win_bit_o) : '0;
  end

endmodule

// File: rtl/irq_tree_ctrl.sv
`timescale 1ns/1ps
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NSUB = 11,
  parameter int DW   = 32,
  parameter logic [NSUB*$clog2(NSRC)-1:0] SUB_PARENT =
    {5'd31, 5'd31, 5'd15, 5'd15, 5'd15, 5'd23, 5'd23, 5'd23, 5'd28, 5'd28, 5'd28}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSUB-1:0] sub_in,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);

  localparam int IW   = $clog2(NSRC);
  localparam int NARB = ARB_IN + 1;

  // Named events and state, visible to the bound checker.
  logic            wr_pend, wr_mode, wr_mask, wr_prio, wr_isr, wr_sub, wr_submask;
  logic [NSRC-1:0] src_pend, src_rise, mask_q, mode_q, isr_q;
  logic [NSUB-1:0] sub_pend, sub_rise, submask_q, sub_req;
  logic [NSRC-1:0] sub_to_main, cand, irq_cand, win_onehot;
  logic [IW-1:0]   offset_q, win_bit;
  logic            tree_any, isr_load;
  logic [NARB*SEL_W-1:0] cfg_sel_wr, sel_rd;
  logic [NARB-1:0]       cfg_rot_wr, rot_rd;

  assign wr_pend    = bus_we && (bus_addr == RA_PEND);
  assign wr_mode    = bus_we && (bus_addr == RA_MODE);
  assign wr_mask    = bus_we && (bus_addr == RA_MASK);
  assign wr_prio    = bus_we && (bus_addr == RA_PRIO);
  assign wr_isr     = bus_we && (bus_addr == RA_INSVC);
  assign wr_sub     = bus_we && (bus_addr == RA_SUBPEND);
  assign wr_submask = bus_we && (bus_addr == RA_SUBMASK);

  irq_edge_latch #(.W(NSUB)) u_sub (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (sub_in),
    .lvl_set_i ('0),
    .clr_we_i  (wr_sub),
    .clr_data_i(bus_wdata[NSUB-1:0]),
    .pend_o    (sub_pend),
    .rise_o    (sub_rise)
  );

  assign sub_req = sub_pend & ~submask_q;

  always_comb begin
    sub_to_main = '0;
    for (int i = 0; i < NSUB; i++) begin
      if (sub_req[i]) sub_to_main[SUB_PARENT[i*IW +: IW]] = 1'b1;
    end
  end

  irq_edge_latch #(.W(NSRC)) u_main (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_in),
    .lvl_set_i (sub_to_main),
    .clr_we_i  (wr_pend),
    .clr_data_i(bus_wdata[NSRC-1:0]),
    .pend_o    (src_pend),
    .rise_o    (src_rise)
  );

  assign cand     = src_pend & ~mask_q;
  assign irq_cand = cand & ~mode_q;
  assign fiq_o    = |(cand & mode_q);

  for (genvar k = 0; k < NARB; k++) begin : g_cfg
    assign cfg_sel_wr[k*SEL_W +: SEL_W] = bus_wdata[k*SEL_W +: SEL_W];
    assign cfg_rot_wr[k]                = bus_wdata[ROT_BASE + k];
  end

  irq_prio_tree #(.NSRC(NSRC)) u_tree (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand_i      (irq_cand),
    .load_i      (isr_load),
    .cfg_we_i    (wr_prio),
    .cfg_sel_i   (cfg_sel_wr),
    .cfg_rot_i   (cfg_rot_wr),
    .sel_o       (sel_rd),
    .rot_o       (rot_rd),
    .any_o       (tree_any),
    .win_bit_o   (win_bit),
    .win_onehot_o(win_onehot)
  );

  assign isr_load = (isr_q == '0) && tree_any;
  assign irq_o    = |isr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '1;
      submask_q <= '1;
      mode_q    <= '0;
      isr_q     <= '0;
      offset_q  <= '0;
    end else begin
      if (wr_mask)    mask_q    <= bus_wdata[NSRC-1:0];
      if (wr_submask) submask_q <= bus_wdata[NSUB-1:0];
      if (wr_mode)    mode_q    <= bus_wdata[NSRC-1:0];
      if (isr_load) begin
        isr_q    <= win_onehot;
        offset_q <= win_bit;
      end else if (wr_isr) begin
        isr_q <= isr_q & ~bus_wdata[NSRC-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_addr_e'(bus_addr))
      RA_PEND:    bus_rdata[NSRC-1:0] = src_pend;
      RA_MODE:    bus_rdata[NSRC-1:0] = mode_q;
      RA_MASK:    bus_rdata[NSRC-1:0] = mask_q;
      RA_PRIO: begin
        bus_rdata[NARB*SEL_W-1:0]           = sel_rd;
        bus_rdata[ROT_BASE +: NARB]         = rot_rd;
      end
      RA_INSVC:   bus_rdata[NSRC-1:0] = isr_q;
      RA_OFFSET:  bus_rdata[IW-1:0]   = offset_q;
      RA_SUBPEND: bus_rdata[NSUB-1:0] = sub_pend;
      RA_SUBMASK: bus_rdata[NSUB-1:0] = submask_q;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_tree_chk.sv
`timescale 1ns/1ps
module irq_tree_chk #(
  parameter int NSRC = 32,
  parameter int NSUB = 11,
  localparam int IW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_rise,
  input logic [NSRC-1:0] src_pend,
  input logic [NSUB-1:0] sub_rise,
  input logic [NSUB-1:0] sub_pend,
  input logic [NSRC-1:0] isr_q,
  input logic [IW-1:0]   offset_q,
  input logic [NSRC-1:0] mode_q,
  input logic [NSRC-1:0] mask_q,
  input logic            isr_load,
  input logic [NSRC-1:0] win_onehot,
  input logic            wr_isr
);

  // R2
  pend_captures_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src_pend & $past(src_rise)) == $past(src_rise)));

  // R10
  sub_captures_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sub_pend & $past(sub_rise)) == $past(sub_rise)));

  // R6
  isr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q));

  // R6
  offset_matches_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q != '0) |-> isr_q[offset_q]);

  // R6
  load_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_load |-> (isr_q == '0));

  // R6
  isr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q != '0) && !wr_isr) |=> (isr_q == $past(isr_q)));

  // R4
  load_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_load |-> ((win_onehot & mask_q) == '0));

  // R5
  load_not_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_load |-> ((win_onehot & mode_q) == '0));

  // R5
  offset_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_load |=> (offset_q == $past(offset_q)));

endmodule

bind irq_tree_ctrl irq_tree_chk #(.NSRC(NSRC), .NSUB(NSUB)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_rise  (src_rise),
  .src_pend  (src_pend),
  .sub_rise  (sub_rise),
  .sub_pend  (sub_pend),
  .isr_q     (isr_q),
  .offset_q  (offset_q),
  .mode_q    (mode_q),
  .mask_q    (mask_q),
  .isr_load  (isr_load),
  .win_onehot(win_onehot),
  .wr_isr    (wr_isr)
);

// File: tb/irq_tree_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_tree_ctrl_tb_top;

  localparam logic [2:0] A_PEND = 3'd0, A_MODE = 3'd1, A_MASK = 3'd2, A_PRIO = 3'd3,
                         A_ISR = 3'd4, A_OFF = 3'd5, A_SUBP = 3'd6, A_SUBM = 3'd7;

  logic        clk, rst_n;
  logic [31:0] src_in;
  logic [10:0] sub_in;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  bit drain_req = 0;

  irq_tree_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .sub_in(sub_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = A_OFF; bus_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
    bus_addr = A_OFF;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse(logic [31:0] bits);
    @(negedge clk); src_in = src_in | bits;
    @(negedge clk); src_in = src_in & ~bits;
  endtask

  task automatic pulse_sub(logic [10:0] bits);
    @(negedge clk); sub_in = sub_in | bits;
    @(negedge clk); sub_in = sub_in & ~bits;
  endtask

  task automatic drain();
    drain_req = 1;
    wait (drain_req == 0);
  endtask

  // Monitor: pops each expected winner once the controller raises irq_o.
  initial begin
    forever begin
      wait (drain_req == 1);
      while (exp_q.size() > 0) begin
        int e, n;
        logic [31:0] v;
        e = exp_q.pop_front();
        n = 0;
        while (!irq_o && n < 200) begin @(negedge clk); n++; end
        rd(A_OFF, v);
        chk("R6 offset of serviced source", v, 32'(e));
        rd(A_ISR, v);
        chk("R6 in-service one-hot", v, 32'd1 << e);
        wr(A_PEND, 32'd1 << e);
        wr(A_ISR, 32'd1 << e);
      end
      drain_req = 0;
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; src_in = '0; sub_in = '0; bus_we = 0; bus_addr = A_OFF; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk("R1 mask", A_MASK, 32'hFFFF_FFFF);
    rd_chk("R1 submask", A_SUBM, 32'h7FF);
    rd_chk("R1 pend", A_PEND, 0);
    rd_chk("R1 mode", A_MODE, 0);
    rd_chk("R1 prio", A_PRIO, 0);
    rd_chk("R1 insvc", A_ISR, 0);
    rd_chk("R1 subpend", A_SUBP, 0);
    chk("R1 irq_o", irq_o, 0);
    chk("R1 fiq_o", fiq_o, 0);

    // R2 latch while masked; R4 masked source stays off the lines
    pulse(32'h20);
    rd_chk("R2 pend set while masked", A_PEND, 32'h20);
    repeat (2) @(negedge clk);
    #1 chk("R4 masked irq_o low", irq_o, 0);
    chk("R4 masked fiq_o low", fiq_o, 0);

    // R3 write-one-to-clear
    wr(A_PEND, 32'h0);
    rd_chk("R3 zeros leave pend", A_PEND, 32'h20);
    wr(A_PEND, 32'h20);
    rd_chk("R3 ones clear pend", A_PEND, 0);

    // R2 held input latches once
    @(negedge clk); src_in[7] = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R2 held input pending", A_PEND, 32'h80);
    wr(A_PEND, 32'h80);
    repeat (3) @(negedge clk);
    rd_chk("R2 held input not relatched", A_PEND, 0);
    @(negedge clk); src_in[7] = 1'b0;

    // R4 unmask and service
    pulse(32'h20);
    wr(A_MASK, ~32'h20);
    exp_q.push_back(5);
    drain();
    @(negedge clk); #1 chk("R6 irq_o low after service", irq_o, 0);
    wr(A_MASK, 32'h0);

    // R8/R7 group 0 on inputs 1..4: select 1 puts bit 1 ahead of bit 0
    wr(A_PRIO, 32'h1);
    pulse(32'h3);
    exp_q.push_back(1); exp_q.push_back(0);
    drain();
    wr(A_PRIO, 32'h0);

    // R7 group-level order
    pulse(32'h8000_0001);
    exp_q.push_back(0); exp_q.push_back(31);
    drain();
    pulse(32'h0001_0010);
    exp_q.push_back(4); exp_q.push_back(16);
    drain();

    // R8 input 0 first, input 5 last under select 3 (group 2 = bits 10..15)
    wr(A_PRIO, 32'h3 << 4);
    pulse(32'h0000_A400);
    exp_q.push_back(10); exp_q.push_back(13); exp_q.push_back(15);
    drain();
    rd_chk("R9 fixed mode select unchanged", A_PRIO, 32'h3 << 4);
    wr(A_PRIO, 32'h0);

    // R6 no replacement of the source in service
    pulse(32'h8000);
    @(negedge clk);
    pulse(32'h0400);
    repeat (2) @(negedge clk);
    rd_chk("R6 in-service kept", A_ISR, 32'h8000);
    rd_chk("R6 offset kept", A_OFF, 15);
    exp_q.push_back(15); exp_q.push_back(10);
    drain();

    // R9 rotation on group 2, R11 priority field layout
    wr(A_PRIO, 32'h1 << 18);
    pulse(32'h1800);
    @(negedge clk);
    rd_chk("R9 select rotated after input 1", A_PRIO, (32'h1 << 18) | (32'h1 << 4));
    exp_q.push_back(11); exp_q.push_back(12);
    drain();
    rd_chk("R9 select rotated after input 2", A_PRIO, (32'h1 << 18) | (32'h2 << 4));
    wr(A_PRIO, 32'h0);

    // R5 fast mode bypasses in-service and offset
    wr(A_MODE, 32'h1 << 20);
    pulse(32'h1 << 20);
    #1 chk("R5 fiq_o high", fiq_o, 1);
    repeat (2) @(negedge clk);
    #1 chk("R5 irq_o low", irq_o, 0);
    rd_chk("R5 insvc untouched", A_ISR, 0);
    rd_chk("R5 offset untouched", A_OFF, 12);
    wr(A_PEND, 32'h1 << 20);
    @(negedge clk); #1 chk("R5 fiq_o drops after clear", fiq_o, 0);
    wr(A_MODE, 32'h0);

    // R11 offset register ignores writes
    wr(A_OFF, 32'h1F);
    rd_chk("R11 offset read-only", A_OFF, 12);

    // R10 secondary sources
    pulse_sub(11'h10);
    rd_chk("R10 subpend set while masked", A_SUBP, 32'h10);
    rd_chk("R10 masked sub leaves parent", A_PEND, 0);
    wr(A_SUBM, 32'h7EF);
    rd_chk("R10 unmasked sub sets parent", A_PEND, 32'h1 << 23);
    wr(A_SUBP, 32'h10);
    rd_chk("R3 subpend cleared", A_SUBP, 0);
    exp_q.push_back(23);
    drain();
    rd_chk("R10 parent stays clear", A_PEND, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule